// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the piece of an I2C master that finishes a byte and finishes a transfer. Once a byte has been received, a pulse on `ack_go` makes it drive the ninth clock pulse. SDA carries either an acknowledge or a not-acknowledge during that pulse. A pulse on `stop_go` starts from a bus where SCL is held low and produces a Stop condition. Every phase of both sequences is timed by a reloadable down-counter, and one bus phase lasts `baud_reload + 1` system clocks.

The block never drives a line high. Its outputs are active-high pull-low enables for open-drain pads, and it reads bus levels only from the sampled pad inputs `scl_in` and `sda_in`. After releasing a line, it waits until that line reads high before it times the next phase. A slave that holds SCL low therefore stretches the sequence.

The block also holds the transmit data buffer and three sticky flags:
- an interrupt flag,
- a write-collision flag,
- a Stop-seen flag.

A buffer write that arrives while a sequence runs is refused and raises the collision flag.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `ack_en`, `stop_en`, all three flags and `buf_q` are 0.
- R2: On `ack_go` in idle, `ack_en` rises and `scl_pull` stays 1 for exactly `baud_reload + 1` cycles. During the whole acknowledge sequence, `sda_pull` equals the inverse of the value of `ack_val` captured at the request (0 = ACK pulls SDA low, 1 = NACK leaves it released).
- R3: After that low phase, SCL is released. The sequencer waits until `scl_in` reads high and then keeps SCL released for `baud_reload + 1` more cycles. If SCL is stretched for S cycles, the released interval is `baud_reload + 2 + S` cycles.
- R4: At the end of the acknowledge sequence, `scl_pull` returns to 1 and stays held in idle. In the same cycle, `ack_en` clears and `irq_flag` sets. `stop_flag` is not touched.
- R5: On `stop_go` in idle, `stop_en` rises and both lines are pulled low. After `sda_in` reads low, SCL stays pulled for `baud_reload + 1` more cycles, so `scl_pull` is 1 for `baud_reload + 2` cycles in all.
- R6: After SCL is released, the sequencer waits until `scl_in` reads high and then counts `baud_reload + 1` cycles before it releases SDA. With S stretch cycles, SDA stays pulled `baud_reload + 2 + S` cycles after SCL is released.
- R7: `stop_flag` sets on the first cycle in which both `sda_in` and `scl_in` read high after SDA has been released. `baud_reload + 1` cycles later, `stop_en` clears and `irq_flag` sets, and both pulls are 0 from then on.
- R8: A `buf_wr` while `ack_en` or `stop_en` is 1 sets `wcol_flag` and leaves `buf_q` unchanged. A `buf_wr` in idle loads `buf_wdata` into `buf_q` and leaves `wcol_flag` unchanged.
- R9: If `ack_go` and `stop_go` arrive in the same cycle, only the acknowledge sequence runs. A request that arrives while a sequence is active is dropped, and `ack_en` and `stop_en` are never 1 together.
- R10: `irq_flag`, `wcol_flag` and `stop_flag` hold until their own clear input (`clr_irq`, `clr_wcol`, `clr_stop`) is 1 at a clock edge. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_go | input | 1 | Request an acknowledge sequence |
| stop_go | input | 1 | Request a Stop sequence |
| ack_val | input | 1 | Acknowledge bit: 0 ACK, 1 NACK |
| baud_reload | input | BAUD_W | Reload value; phase length is value + 1 clocks |
| scl_in | input | 1 | Sampled SCL pad level |
| sda_in | input | 1 | Sampled SDA pad level |
| buf_wr | input | 1 | Write strobe for the data buffer |
| buf_wdata | input | DATA_W | Data for a buffer write |
| clr_irq | input | 1 | Clear the interrupt flag |
| clr_wcol | input | 1 | Clear the write-collision flag |
| clr_stop | input | 1 | Clear the Stop-seen flag |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| ack_en | output | 1 | Acknowledge sequence running (clears itself) |
| stop_en | output | 1 | Stop sequence running (clears itself) |
| stop_flag | output | 1 | Sticky Stop-seen flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| buf_q | output | DATA_W | Data buffer contents |

## Verification
The assertions assume three things about the inputs:
- `ack_val` is held steady for as long as `ack_en` is 1.
- `clr_stop` is not pulsed during a Stop sequence.
- The pad inputs reflect the pull outputs, except where another device holds a line low.

The bench models the pads as open-drain wires built from the pull outputs plus bench-controlled stretch holds. It changes `ack_val` and `baud_reload` only while the block is idle, and it raises clear pulses only in idle or in the single directed case where a clear is held across the acknowledge completion.

// File: rtl/i2c_ackstop_pkg.sv
package i2c_ackstop_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ACK_LOW,
        SQ_ACK_REL,
        SQ_ACK_HIGH,
        SQ_STP_SDA,
        SQ_STP_SCL,
        SQ_STP_REL,
        SQ_STP_HIGH,
        SQ_STP_SDAREL,
        SQ_STP_TAIL
    } seq_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drv_t;

    typedef struct packed {
        logic load;
        logic irq_ev;
        logic stop_ev;
    } seq_evt_t;

    localparam int NUM_FLAGS = 3;
    localparam int FLG_IRQ   = 0;
    localparam int FLG_WCOL  = 1;
    localparam int FLG_STOP  = 2;

    function automatic logic in_ack(input seq_state_e s);
        return (s == SQ_ACK_LOW) || (s == SQ_ACK_REL) || (s == SQ_ACK_HIGH);
    endfunction

    function automatic logic in_stop(input seq_state_e s);
        return (s != SQ_IDLE) && !in_ack(s);
    endfunction

    function automatic line_drv_t drive_for(input seq_state_e s,
                                            input logic held,
                                            input logic ack_bit);
        line_drv_t d;
        unique case (s)
            SQ_IDLE:       begin d.scl_low = held; d.sda_low = 1'b0;     end
            SQ_ACK_LOW:    begin d.scl_low = 1'b1; d.sda_low = !ack_bit; end
            SQ_ACK_REL,
            SQ_ACK_HIGH:   begin d.scl_low = 1'b0; d.sda_low = !ack_bit; end
            SQ_STP_SDA,
            SQ_STP_SCL:    begin d.scl_low = 1'b1; d.sda_low = 1'b1;     end
            SQ_STP_REL,
            SQ_STP_HIGH:   begin d.scl_low = 1'b0; d.sda_low = 1'b1;     end
            default:       begin d.scl_low = 1'b0; d.sda_low = 1'b0;     end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BAUD_W-1:0] reload,
    output logic              done
);
    logic [BAUD_W-1:0] cnt;
    logic              run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= reload;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_ackstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_req,
    input  logic       stop_req,
    input  logic       ack_val,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       tmr_done,
    output seq_state_e state_o,
    output line_drv_t  drv_o,
    output seq_evt_t   evt_o
);
    seq_state_e state, state_nx;
    logic       held, held_nx;
    logic       ack_bit;

    always_comb begin
        state_nx = state;
        held_nx  = held;
        evt_o    = '0;
        unique case (state)
            SQ_IDLE: begin
                if (ack_req) begin
                    state_nx   = SQ_ACK_LOW;
                    evt_o.load = 1'b1;
                end else if (stop_req) begin
                    state_nx = SQ_STP_SDA;
                end
            end
            SQ_ACK_LOW:  if (tmr_done) state_nx = SQ_ACK_REL;
            SQ_ACK_REL: begin
                if (scl_in) begin
                    state_nx   = SQ_ACK_HIGH;
                    evt_o.load = 1'b1;
                end
            end
            SQ_ACK_HIGH: begin
                if (tmr_done) begin
                    state_nx     = SQ_IDLE;
                    evt_o.irq_ev = 1'b1;
                    held_nx      = 1'b1;
                end
            end
            SQ_STP_SDA: begin
                if (!sda_in) begin
                    state_nx   = SQ_STP_SCL;
                    evt_o.load = 1'b1;
                end
            end
            SQ_STP_SCL:  if (tmr_done) state_nx = SQ_STP_REL;
            SQ_STP_REL: begin
                if (scl_in) begin
                    state_nx   = SQ_STP_HIGH;
                    evt_o.load = 1'b1;
                end
            end
            SQ_STP_HIGH: if (tmr_done) state_nx = SQ_STP_SDAREL;
            SQ_STP_SDAREL: begin
                if (sda_in && scl_in) begin
                    state_nx      = SQ_STP_TAIL;
                    evt_o.load    = 1'b1;
                    evt_o.stop_ev = 1'b1;
                end
            end
            SQ_STP_TAIL: begin
                if (tmr_done) begin
                    state_nx     = SQ_IDLE;
                    evt_o.irq_ev = 1'b1;
                    held_nx      = 1'b0;
                end
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            held    <= 1'b0;
            ack_bit <= 1'b0;
        end else begin
            state <= state_nx;
            held  <= held_nx;
            if (state == SQ_IDLE && ack_req) ack_bit <= ack_val;
        end
    end

    assign state_o = state;
    assign drv_o   = drive_for(state, held, ack_bit);
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
    import i2c_ackstop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy,
    input  logic                 buf_wr,
    input  logic [DATA_W-1:0]    buf_wdata,
    input  logic [NUM_FLAGS-1:0] set_v,
    input  logic [NUM_FLAGS-1:0] clr_v,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [DATA_W-1:0]    buf_q
);
    logic [NUM_FLAGS-1:0] set_all;

    always_comb begin
        set_all           = set_v;
        set_all[FLG_WCOL] = set_v[FLG_WCOL] | (buf_wr & busy);
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_all[i]) flags[i] <= 1'b1;
            else if (clr_v[i])   flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 buf_q <= '0;
        else if (buf_wr && !busy) buf_q <= buf_wdata;
    end
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq
    import i2c_ackstop_pkg::*;
#(
    parameter int BAUD_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_go,
    input  logic              stop_go,
    input  logic              ack_val,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              clr_irq,
    input  logic              clr_wcol,
    input  logic              clr_stop,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              ack_en,
    output logic              stop_en,
    output logic              stop_flag,
    output logic              irq_flag,
    output logic              wcol_flag,
    output logic [DATA_W-1:0] buf_q
);
    seq_state_e           state;
    line_drv_t            drv;
    seq_evt_t             evt;
    logic                 tmr_done;
    logic [NUM_FLAGS-1:0] set_v, clr_v, flags;

    i2c_baud_timer #(.BAUD_W(BAUD_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (evt.load),
        .reload (baud_reload),
        .done   (tmr_done)
    );

    i2c_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ack_req  (ack_go),
        .stop_req (stop_go),
        .ack_val  (ack_val),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .tmr_done (tmr_done),
        .state_o  (state),
        .drv_o    (drv),
        .evt_o    (evt)
    );

    always_comb begin
        set_v           = '0;
        set_v[FLG_IRQ]  = evt.irq_ev;
        set_v[FLG_STOP] = evt.stop_ev;
        clr_v           = '0;
        clr_v[FLG_IRQ]  = clr_irq;
        clr_v[FLG_WCOL] = clr_wcol;
        clr_v[FLG_STOP] = clr_stop;
    end

    i2c_flag_bank #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .busy      (state != SQ_IDLE),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .set_v     (set_v),
        .clr_v     (clr_v),
        .flags     (flags),
        .buf_q     (buf_q)
    );

    assign scl_pull  = drv.scl_low;
    assign sda_pull  = drv.sda_low;
    assign ack_en    = in_ack(state);
    assign stop_en   = in_stop(state);
    assign irq_flag  = flags[FLG_IRQ];
    assign wcol_flag = flags[FLG_WCOL];
    assign stop_flag = flags[FLG_STOP];
endmodule

// File: rtl/i2c_ackstop_chk.sv
module i2c_ackstop_chk #(
    parameter int BAUD_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_val,
    input logic              scl_in,
    input logic              sda_in,
    input logic              buf_wr,
    input logic              clr_irq,
    input logic              scl_pull,
    input logic              sda_pull,
    input logic              ack_en,
    input logic              stop_en,
    input logic              stop_flag,
    input logic              irq_flag,
    input logic              wcol_flag,
    input logic [DATA_W-1:0] buf_q
);
    a_r2_ack_sda: assert property (@(posedge clk) disable iff (rst)
        ack_en |-> (sda_pull == !ack_val));

    a_r2_ack_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_en) |-> scl_pull);

    a_r4_ack_end: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_en) |-> (irq_flag && scl_pull));

    a_r7_stop_end: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_en) |-> (irq_flag && stop_flag && !scl_pull && !sda_pull));

    a_r7_flag_lines: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_flag) |-> $past(sda_in && scl_in));

    a_r8_buf_hold: assert property (@(posedge clk) disable iff (rst)
        ((ack_en || stop_en) && buf_wr) |=> (wcol_flag && $stable(buf_q)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ack_en && stop_en));

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !clr_irq) |=> irq_flag);
endmodule

bind i2c_ackstop_seq i2c_ackstop_chk #(.BAUD_W(BAUD_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack_val   (ack_val),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .buf_wr    (buf_wr),
    .clr_irq   (clr_irq),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .ack_en    (ack_en),
    .stop_en   (stop_en),
    .stop_flag (stop_flag),
    .irq_flag  (irq_flag),
    .wcol_flag (wcol_flag),
    .buf_q     (buf_q)
);

// File: tb/i2c_ackstop_seq_tb.sv
`timescale 1ns/1ps
module i2c_ackstop_seq_tb;
    localparam int BW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ack_go = 0, stop_go = 0, ack_val = 0;
    logic [BW-1:0] baud_reload = '0;
    logic          buf_wr = 0;
    logic [DW-1:0] buf_wdata = '0;
    logic          clr_irq = 0, clr_wcol = 0, clr_stop = 0;
    logic          scl_hold = 0, sda_hold = 0;
    logic          scl_in, sda_in;
    logic          scl_pull, sda_pull, ack_en, stop_en;
    logic          stop_flag, irq_flag, wcol_flag;
    logic [DW-1:0] buf_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    assign scl_in = !scl_pull && !scl_hold;
    assign sda_in = !sda_pull && !sda_hold;

    i2c_ackstop_seq #(.BAUD_W(BW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .ack_go(ack_go), .stop_go(stop_go),
        .ack_val(ack_val), .baud_reload(baud_reload),
        .scl_in(scl_in), .sda_in(sda_in), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .clr_irq(clr_irq), .clr_wcol(clr_wcol),
        .clr_stop(clr_stop), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .ack_en(ack_en), .stop_en(stop_en), .stop_flag(stop_flag),
        .irq_flag(irq_flag), .wcol_flag(wcol_flag), .buf_q(buf_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ack_rel_len(input int r, input int s);
        return r + 2 + s;
    endfunction

    task automatic clear_all();
        clr_irq = 1; clr_wcol = 1; clr_stop = 1;
        @(negedge clk);
        clr_irq = 0; clr_wcol = 0; clr_stop = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && (ack_en || stop_en); i++) @(negedge clk);
    endtask

    task automatic run_ack(input int r, input int s, input bit bitv, input bit hold_clr);
        int lo, rel, bad;
        baud_reload = BW'(r);
        ack_val = bitv;
        ack_go = 1;
        if (hold_clr) clr_irq = 1;
        @(negedge clk);
        ack_go = 0;
        chk(ack_en == 1, "R2 ack_en raised", ack_en, 1);
        lo = 0; bad = 0;
        while (scl_pull && lo < 1000) begin
            if (sda_pull != !bitv) bad++;
            lo++;
            @(negedge clk);
        end
        chk(lo == r + 1, "R2 scl low phase", lo, r + 1);
        scl_hold = (s > 0);
        rel = 0;
        while (!scl_pull && rel < 1000) begin
            if (sda_pull != !bitv) bad++;
            rel++;
            if (rel == s + 1) scl_hold = 0;
            @(negedge clk);
        end
        scl_hold = 0;
        chk(rel == ack_rel_len(r, s), "R3 scl released interval", rel, ack_rel_len(r, s));
        chk(bad == 0, "R2 sda follows ack value", bad, 0);
        chk(ack_en == 0, "R4 ack_en cleared", ack_en, 0);
        chk(irq_flag == 1, hold_clr ? "R10 set wins over clear" : "R4 irq set", irq_flag, 1);
        chk(scl_pull == 1 && sda_pull == 0, "R4 idle holds scl", {scl_pull, sda_pull}, 2);
        if (hold_clr) begin
            @(negedge clk);
            clr_irq = 0;
            chk(irq_flag == 0, "R10 clear pulse", irq_flag, 0);
        end
    endtask

    task automatic run_stop(input int r, input int s, input int h);
        int a, b, c, d, bad;
        baud_reload = BW'(r);
        stop_go = 1;
        @(negedge clk);
        stop_go = 0;
        chk(stop_en == 1, "R5 stop_en raised", stop_en, 1);
        a = 0; bad = 0;
        while (scl_pull && a < 1000) begin
            if (!sda_pull) bad++;
            a++;
            @(negedge clk);
        end
        chk(a == r + 2, "R5 scl pulled interval", a, r + 2);
        scl_hold = (s > 0);
        b = 0;
        while (sda_pull && b < 1000) begin
            if (scl_pull) bad++;
            b++;
            if (b == s + 1) scl_hold = 0;
            @(negedge clk);
        end
        scl_hold = 0;
        chk(b == r + 2 + s, "R6 sda held after scl release", b, r + 2 + s);
        chk(bad == 0, "R6 line order", bad, 0);
        sda_hold = (h > 0);
        c = 0;
        while (!stop_flag && c < 1000) begin
            c++;
            if (c == h + 1) sda_hold = 0;
            @(negedge clk);
        end
        sda_hold = 0;
        chk(c == h + 1, "R7 stop flag latency", c, h + 1);
        d = 0;
        while (!irq_flag && d < 1000) begin
            d++;
            @(negedge clk);
        end
        chk(d == r + 1, "R7 tail before irq", d, r + 1);
        chk(stop_en == 0 && stop_flag == 1, "R7 stop_en cleared", {stop_en, stop_flag}, 1);
        chk(scl_pull == 0 && sda_pull == 0, "R7 lines released", {scl_pull, sda_pull}, 0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] old;
        void'($urandom(32'h1C2A_0517));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({scl_pull, sda_pull, ack_en, stop_en} == 0, "R1 reset lines", {scl_pull, sda_pull, ack_en, stop_en}, 0);
        chk({stop_flag, irq_flag, wcol_flag} == 0 && buf_q == 0, "R1 reset flags", {stop_flag, irq_flag, wcol_flag}, 0);

        run_ack(0, 0, 0, 0);
        clear_all();
        run_ack(5, 3, 1, 0);
        chk(stop_flag == 0, "R4 stop flag untouched", stop_flag, 0);
        clear_all();
        run_stop(0, 0, 0);
        clear_all();
        run_stop(3, 2, 2);
        clear_all();
        run_ack(2, 1, 0, 1);

        // R8 collision during ack, then idle write
        buf_wdata = 8'h3C; buf_wr = 1; @(negedge clk); buf_wr = 0;
        chk(buf_q == 8'h3C && wcol_flag == 0, "R8 idle write loads", buf_q, 8'h3C);
        baud_reload = 8'd10; ack_go = 1; @(negedge clk); ack_go = 0;
        buf_wdata = 8'hA5; buf_wr = 1; @(negedge clk); buf_wr = 0;
        chk(wcol_flag == 1, "R8 wcol during ack", wcol_flag, 1);
        chk(buf_q == 8'h3C, "R8 buffer kept during ack", buf_q, 8'h3C);
        wait_idle();
        @(negedge clk);
        buf_wdata = 8'h71; buf_wr = 1; @(negedge clk); buf_wr = 0;
        chk(buf_q == 8'h71 && wcol_flag == 1, "R8 idle write, wcol sticky", buf_q, 8'h71);
        clr_wcol = 1; @(negedge clk); clr_wcol = 0;
        chk(wcol_flag == 0, "R10 wcol cleared", wcol_flag, 0);
        stop_go = 1; @(negedge clk); stop_go = 0;
        buf_wdata = 8'h0F; buf_wr = 1; @(negedge clk); buf_wr = 0;
        chk(wcol_flag == 1 && buf_q == 8'h71, "R8 wcol during stop", buf_q, 8'h71);
        wait_idle();
        clear_all();

        // R9 priority and dropped requests
        baud_reload = 8'd4; ack_val = 0;
        ack_go = 1; stop_go = 1; @(negedge clk); ack_go = 0; stop_go = 0;
        chk(ack_en == 1 && stop_en == 0, "R9 ack wins", {ack_en, stop_en}, 2);
        @(negedge clk);
        stop_go = 1; @(negedge clk); stop_go = 0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk(stop_en == 0 && stop_flag == 0, "R9 request during ack dropped", {stop_en, stop_flag}, 0);
        clear_all();
        chk(irq_flag == 0, "R10 irq cleared", irq_flag, 0);
        repeat (2) @(negedge clk);
        chk(irq_flag == 0 && stop_flag == 0, "R10 flags stay clear", {irq_flag, stop_flag}, 0);

        for (int k = 0; k < 40; k++) begin
            int r, s, h;
            r = $urandom_range(0, 7);
            s = $urandom_range(0, 3);
            h = $urandom_range(0, 2);
            if ($urandom_range(0, 1) == 1) run_ack(r, s, 1'($urandom_range(0, 1)), 0);
            else                           run_stop(r, s, h);
            clear_all();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule